// File: doc/BRIEF.md
# Capability Register File with Masked Writes

This block is a bank of 32-bit control and status registers that sits in the cache/memory window of a memory-expansion component. Software reaches it through a simple request bus. Each request carries a valid flag, a write flag, a byte address, a flag for an 8-byte access, and write data. Read data comes back one clock later.

The bank opens with a capability header and an array of capability entries. The number of entries depends on the component kind, which is set by a parameter. An error-reporting group and an address-decoder group follow the array.

Each register has a fixed write mask, so a write changes only the bits the mask allows. When decoder 0's control register is written with its commit request set, the stored value turns the request into a sticky committed flag in the same clock.

Top module: `capreg_file`

## Requirements
- R1: After reset, the header at 0x000 reads {arraySize[31:24], 4'h1, 4'h1, 16'h0001}. arraySize is 2 for a downstream port or a generic device, 3 for an upstream port, a type-3 device or a logical device, and 5 for a root port.
- R2: The capability entries sit at 0x004 to 0x014 in a fixed order, and each holds {ptr[31:20], ver[19:16], id[15:0]}.
  - The entries are: error group 0x10020002, link 0x18020004, decoder group 0x20010005, security 0x28010006 and snoop 0x2A010008.
  - Entries beyond arraySize read 0 and ignore writes.
- R3: The error group has these registers, with these reset values and write masks:

  | Address | Register | Reset value | Write mask |
  |---|---|---|---|
  | 0x100 | uncorrectable status | 0 | 0x1CFFF |
  | 0x104 | uncorrectable mask | 0x1CFFF | 0x1CFFF |
  | 0x108 | uncorrectable severity | 0x1CFFF | 0x1CFFF |
  | 0x10C | correctable status | 0 | 0x7F |
  | 0x110 | correctable mask | 0x7F | 0x7F |
  | 0x114 | capability/control | 0x200 | read-only |

- R4: The decoder capability at 0x200 reads 0x310. This encodes one decoder, a target count of 1, 256-byte and 4 KiB interleave support, and no poison support. The global control at 0x204 resets to 0.
- R5: A 4-byte aligned write stores (wdata & mask) | (old & ~mask).
  - Global control 0x204 has mask 0x3.
  - Base-low 0x210 and size-low 0x218 have mask 0xF0000000.
  - Base-high 0x214, size-high 0x21C and target-high 0x228 have mask 0xFFFFFFFF.
  - Control 0x220 has mask 0x13FF.
- R6: Registers whose mask is 0 (the header, the entries, the error capability and the decoder capability) keep their value through any write.
- R7: A write to the control register 0x220 whose stored value has bit 9 (commit) set stores the value with bit 9 and bit 11 (error) cleared and bit 10 (committed) set. Bit 10 cannot be written, so it stays set until reset.
- R8: Target-low 0x224 has mask 0xF0000000 for device kinds and 0xFFFFFFFF for port kinds.
- R9: An 8-byte access returns 0 on a read and changes nothing on a write.
- R10: An access whose address is unaligned or maps to no present register reads 0 and is ignored on a write.
- R11: Read data appears in the cycle after the read request and is 0 in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize8 | input | 1 | 1 = 8-byte access (not serviced) |
| reqAddr | input | ADDR_W | Byte address in the window |
| reqWdata | input | 32 | Write data |
| rdData | output | 32 | Read data, one cycle after the request |

## Verification
The committed flag is the hardest state to reach and to tell apart from ordinary storage. It can never be written directly, so it shows up only after a commit write. The bench first writes a control value without the commit bit and checks that the flag stays clear. It then writes all ones, which must read back as 0x15FF. Finally it writes zero and checks that bit 10 alone survives. The bench also runs a root-port instance beside the default type-3 instance from the same bus, so that the entry count and the target-low mask are checked for both kinds.

// File: rtl/capreg_pkg.sv
package capreg_pkg;

  typedef enum logic [2:0] {
    KIND_DSP    = 3'd0,
    KIND_GENDEV = 3'd1,
    KIND_USP    = 3'd2,
    KIND_T3     = 3'd3,
    KIND_LOGDEV = 3'd4,
    KIND_RP     = 3'd5
  } compKind_e;

  localparam int NREG  = 21;
  localparam int IDX_W = $clog2(NREG);

  localparam int IX_HDR  = 0;
  localparam int IX_ENT0 = 1;   // entries 1..5
  localparam int IX_UST  = 6;
  localparam int IX_UMSK = 7;
  localparam int IX_USEV = 8;
  localparam int IX_CST  = 9;
  localparam int IX_CMSK = 10;
  localparam int IX_ECAP = 11;
  localparam int IX_HCAP = 12;
  localparam int IX_HGBL = 13;
  localparam int IX_BLO  = 14;
  localparam int IX_BHI  = 15;
  localparam int IX_SLO  = 16;
  localparam int IX_SHI  = 17;
  localparam int IX_DCTL = 18;
  localparam int IX_TLO  = 19;
  localparam int IX_THI  = 20;

  localparam int BIT_COMMIT    = 9;
  localparam int BIT_COMMITTED = 10;
  localparam int BIT_ERR       = 11;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic [IDX_W-1:0] sel;
  } regStb_t;

  function automatic logic [11:0] addrOf(input int idx);
    case (idx)
      IX_HDR:  return 12'h000;
      1:       return 12'h004;
      2:       return 12'h008;
      3:       return 12'h00C;
      4:       return 12'h010;
      5:       return 12'h014;
      IX_UST:  return 12'h100;
      IX_UMSK: return 12'h104;
      IX_USEV: return 12'h108;
      IX_CST:  return 12'h10C;
      IX_CMSK: return 12'h110;
      IX_ECAP: return 12'h114;
      IX_HCAP: return 12'h200;
      IX_HGBL: return 12'h204;
      IX_BLO:  return 12'h210;
      IX_BHI:  return 12'h214;
      IX_SLO:  return 12'h218;
      IX_SHI:  return 12'h21C;
      IX_DCTL: return 12'h220;
      IX_TLO:  return 12'h224;
      default: return 12'h228;
    endcase
  endfunction

  function automatic int capsFor(input compKind_e k);
    case (k)
      KIND_DSP, KIND_GENDEV:           return 2;
      KIND_USP, KIND_T3, KIND_LOGDEV:  return 3;
      default:                         return 5;
    endcase
  endfunction

  function automatic bit isDevice(input compKind_e k);
    return (k == KIND_GENDEV) || (k == KIND_T3) || (k == KIND_LOGDEV);
  endfunction

  function automatic bit presentFor(input int idx, input compKind_e k);
    if (idx >= IX_ENT0 && idx <= 5)  return (idx <= capsFor(k));
    if (idx >= IX_HCAP)              return (capsFor(k) >= 3);
    return 1'b1;
  endfunction

  function automatic logic [31:0] entryVal(input int n);
    case (n)
      1:       return {12'h100, 4'h2, 16'h0002};
      2:       return {12'h180, 4'h2, 16'h0004};
      3:       return {12'h200, 4'h1, 16'h0005};
      4:       return {12'h280, 4'h1, 16'h0006};
      default: return {12'h2A0, 4'h1, 16'h0008};
    endcase
  endfunction

  function automatic logic [31:0] resetFor(input int idx, input compKind_e k);
    if (!presentFor(idx, k)) return 32'h0;
    if (idx >= IX_ENT0 && idx <= 5) return entryVal(idx);
    case (idx)
      IX_HDR:           return {8'(capsFor(k)), 4'h1, 4'h1, 16'h0001};
      IX_UMSK, IX_USEV: return 32'h0001_CFFF;
      IX_CMSK:          return 32'h0000_007F;
      IX_ECAP:          return 32'h0000_0200;
      IX_HCAP:          return 32'h0000_0310;
      default:          return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] maskFor(input int idx, input compKind_e k);
    case (idx)
      IX_UST, IX_UMSK, IX_USEV: return 32'h0001_CFFF;
      IX_CST, IX_CMSK:          return 32'h0000_007F;
      IX_HGBL:                  return 32'h0000_0003;
      IX_BLO, IX_SLO:           return 32'hF000_0000;
      IX_BHI, IX_SHI, IX_THI:   return 32'hFFFF_FFFF;
      IX_DCTL:                  return 32'h0000_13FF;
      IX_TLO:                   return isDevice(k) ? 32'hF000_0000 : 32'hFFFF_FFFF;
      default:                  return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/capreg_ctrl.sv
module capreg_ctrl
  import capreg_pkg::*;
#(
  parameter compKind_e KIND   = KIND_T3,
  parameter int        ADDR_W = 12
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSize8,
  input  logic [ADDR_W-1:0] reqAddr,
  output regStb_t           stb
);

  logic             hit;
  logic [IDX_W-1:0] hitIdx;
  logic             serviceable;

  assign serviceable = reqValid && !reqSize8 && (reqAddr[1:0] == 2'b00);

  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (presentFor(i, KIND) && (reqAddr == ADDR_W'(addrOf(i)))) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    stb.wr  = serviceable && hit && reqWrite;
    stb.rd  = serviceable && hit && !reqWrite;
    stb.sel = hitIdx;
  end

endmodule

// File: rtl/capreg_dp.sv
module capreg_dp
  import capreg_pkg::*;
#(
  parameter compKind_e KIND = KIND_T3
) (
  input  logic        clk,
  input  logic        rst,
  input  regStb_t     stb,
  input  logic [31:0] wdata,
  output logic [31:0] rdData
);

  logic [31:0] regVec [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [31:0] MASK  = maskFor(i, KIND);
    localparam logic [31:0] RSTV  = resetFor(i, KIND);
    logic [31:0] q;
    logic [31:0] merged;
    logic [31:0] nextVal;

    assign merged = (wdata & MASK) | (q & ~MASK);

    if (i == IX_DCTL) begin : g_commit
      always_comb begin
        nextVal = merged;
        if (merged[BIT_COMMIT]) begin
          nextVal[BIT_COMMIT]    = 1'b0;
          nextVal[BIT_ERR]       = 1'b0;
          nextVal[BIT_COMMITTED] = 1'b1;
        end
      end
    end else begin : g_plain
      assign nextVal = merged;
    end

    always_ff @(posedge clk) begin
      if (rst)                                  q <= RSTV;
      else if (stb.wr && stb.sel == IDX_W'(i))  q <= nextVal;
    end

    assign regVec[i] = q;
  end

  always_ff @(posedge clk) begin
    if (rst)         rdData <= '0;
    else if (stb.rd) rdData <= regVec[stb.sel];
    else             rdData <= '0;
  end

endmodule

// File: rtl/capreg_file.sv
module capreg_file
  import capreg_pkg::*;
#(
  parameter compKind_e KIND   = KIND_T3,
  parameter int        ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSize8,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic [31:0]       rdData
);

  regStb_t stb;

  capreg_ctrl #(.KIND(KIND), .ADDR_W(ADDR_W)) u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqSize8 (reqSize8),
    .reqAddr  (reqAddr),
    .stb      (stb)
  );

  capreg_dp #(.KIND(KIND)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .wdata  (reqWdata),
    .rdData (rdData)
  );

endmodule

// File: rtl/capreg_file_chk.sv
module capreg_file_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqSize8,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [31:0]       rdData
);

  logic isRead;
  assign isRead = reqValid && !reqWrite;

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !isRead |=> rdData == 32'h0);

  // R9
  wide_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    isRead && reqSize8 |=> rdData == 32'h0);

  // R10
  unaligned_zero_chk: assert property (@(posedge clk) disable iff (rst)
    isRead && (reqAddr[1:0] != 2'b00) |=> rdData == 32'h0);

  // R7
  commit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    isRead && !reqSize8 && reqAddr == ADDR_W'(12'h220) |=> !rdData[9] && !rdData[11]);

  // R1
  header_fields_chk: assert property (@(posedge clk) disable iff (rst)
    isRead && !reqSize8 && reqAddr == '0 |=> rdData[23:0] == 24'h110001);

endmodule

bind capreg_file capreg_file_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqSize8 (reqSize8),
  .reqAddr  (reqAddr),
  .rdData   (rdData)
);

// File: tb/capreg_file_bench.sv
module capreg_file_bench;
  import capreg_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqSize8 = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [31:0] rdT3;
  logic [31:0] rdRp;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  capreg_file #(.KIND(KIND_T3), .ADDR_W(12)) u_capreg_file (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize8(reqSize8), .reqAddr(reqAddr), .reqWdata(reqWdata), .rdData(rdT3));

  capreg_file #(.KIND(KIND_RP), .ADDR_W(12)) u_capreg_file_rp (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize8(reqSize8), .reqAddr(reqAddr), .reqWdata(reqWdata), .rdData(rdRp));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic wide = 1'b0);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqSize8 = wide; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0; reqSize8 = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] t3, output logic [31:0] rp,
                    input logic wide = 1'b0);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqSize8 = wide; reqAddr = a;
    @(negedge clk);
    t3 = rdT3; rp = rdRp;
    reqValid = 1'b0; reqSize8 = 1'b0;
  endtask

  task automatic test_header;
    logic [31:0] a, b;
    rd(12'h000, a, b);
    check("R1 hdr t3", a, 32'h0311_0001);
    check("R1 hdr rp", b, 32'h0511_0001);
    rd(12'h004, a, b); check("R2 ent ras", a, 32'h1002_0002);
    rd(12'h00C, a, b); check("R2 ent hdm", a, 32'h2001_0005);
    rd(12'h010, a, b);
    check("R2 ent4 absent t3", a, 32'h0);
    check("R2 ent4 rp", b, 32'h2801_0006);
    rd(12'h014, a, b); check("R2 ent5 rp", b, 32'h2A01_0008);
  endtask

  task automatic test_ras_reset;
    logic [31:0] a, b;
    rd(12'h100, a, b); check("R3 unc status", a, 32'h0);
    rd(12'h104, a, b); check("R3 unc mask", a, 32'h0001_CFFF);
    rd(12'h108, a, b); check("R3 unc sev", a, 32'h0001_CFFF);
    rd(12'h110, a, b); check("R3 cor mask", a, 32'h0000_007F);
    rd(12'h114, a, b); check("R3 errcap", a, 32'h0000_0200);
  endtask

  task automatic test_hdm_reset;
    logic [31:0] a, b;
    rd(12'h200, a, b); check("R4 hdm cap", a, 32'h0000_0310);
    rd(12'h204, a, b); check("R4 gbl ctl", a, 32'h0);
  endtask

  task automatic test_masked;
    logic [31:0] a, b;
    wr(12'h104, 32'h0);        rd(12'h104, a, b); check("R5 unc mask clear", a, 32'h0);
    wr(12'h10C, 32'hFFFF_FFFF); rd(12'h10C, a, b); check("R5 cor status", a, 32'h7F);
    wr(12'h204, 32'hFFFF_FFFF); rd(12'h204, a, b); check("R5 gbl ctl", a, 32'h3);
    wr(12'h210, 32'hFFFF_FFFF); rd(12'h210, a, b); check("R5 base lo", a, 32'hF000_0000);
    wr(12'h21C, 32'h1234_5678); rd(12'h21C, a, b); check("R5 size hi", a, 32'h1234_5678);
  endtask

  task automatic test_readonly;
    logic [31:0] a, b;
    wr(12'h114, 32'h0);         rd(12'h114, a, b); check("R6 errcap", a, 32'h200);
    wr(12'h000, 32'hFFFF_FFFF); rd(12'h000, a, b); check("R6 header", a, 32'h0311_0001);
    wr(12'h200, 32'h0);         rd(12'h200, a, b); check("R6 hdm cap", a, 32'h310);
  endtask

  task automatic test_commit;
    logic [31:0] a, b;
    wr(12'h220, 32'h0000_01A5); rd(12'h220, a, b); check("R7 ctrl no commit", a, 32'h1A5);
    wr(12'h220, 32'hFFFF_FFFF); rd(12'h220, a, b); check("R7 commit", a, 32'h15FF);
    wr(12'h220, 32'h0);         rd(12'h220, a, b); check("R7 committed sticky", a, 32'h400);
  endtask

  task automatic test_target;
    logic [31:0] a, b;
    wr(12'h224, 32'hFFFF_FFFF); rd(12'h224, a, b);
    check("R8 tlo device", a, 32'hF000_0000);
    check("R8 tlo port", b, 32'hFFFF_FFFF);
  endtask

  task automatic test_wide;
    logic [31:0] a, b;
    wr(12'h108, 32'h0, 1'b1);   rd(12'h108, a, b); check("R9 wide write discarded", a, 32'h1CFFF);
    rd(12'h108, a, b, 1'b1);    check("R9 wide read zero", a, 32'h0);
  endtask

  task automatic test_unmapped;
    logic [31:0] a, b;
    wr(12'h101, 32'hFFFF_FFFF); rd(12'h100, a, b); check("R10 unaligned write", a, 32'h0);
    rd(12'h109, a, b);          check("R10 unaligned read", a, 32'h0);
    wr(12'h180, 32'hFFFF_FFFF); rd(12'h180, a, b); check("R10 unmapped", a, 32'h0);
    wr(12'h010, 32'hFFFF_FFFF); rd(12'h010, a, b); check("R10 absent entry", a, 32'h0);
  endtask

  task automatic test_latency;
    logic [31:0] a, b;
    rd(12'h104, a, b);
    check("R11 one-cycle data", a, 32'h0);
    rd(12'h108, a, b);
    check("R11 one-cycle data sev", a, 32'h1CFFF);
    @(negedge clk);
    check("R11 idle zero", rdT3, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset rdData", rdT3, 32'h0);
    rst = 1'b0;
    test_header();
    test_ras_reset();
    test_hdm_reset();
    test_masked();
    test_readonly();
    test_commit();
    test_target();
    test_wide();
    test_unmapped();
    test_latency();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule